// File: doc/BRIEF.md
# Ring Frame Header Router and Transmit Merger

This block sits between the receive side and the transmit side of a node on a one-way ring. Each decoded frame arrives as one 40-bit beat: an 8-bit header followed by a 32-bit payload. The router reads the header and sends the frame to one or more places. These are the local application, the local synchronization logic, or a forwarding queue that passes the frame on to the next node. Which places it picks depends on the frame's origin bit, its 3-bit node ID and its 4-bit type. It also depends on whether this node is the ring master. One node ID is kept for frames addressed to every slave.

On the transmit side, three source queues feed a single transmitter. The synchronization logic, the forwarding path and the application each have a queue of their own, so any of them can inject a frame at any time. A merger takes one whole frame at a time, only when the transmitter can accept it. It picks by fixed priority: synchronization first, then forwarding, then application. Every interface is a valid/ready stream that carries one frame per beat. The node role and node ID are static configuration inputs.

Top module: `ring_frame_switch`

## Requirements
- R1: A frame whose type field (bits 35:32) is 12 to 15 goes to the synchronization output only, whatever its origin, node ID or the node's role.
- R2: At a slave, a non-sync frame with origin bit 39 set (master-started) and node ID (bits 38:36) equal to `node_id` goes to the application output only.
- R3: At a slave, a non-sync master-started frame with node ID 7 (multicast) goes to the application output and is also forwarded.
- R4: At a slave, every other non-sync frame is forwarded only. This covers all slave-started frames and master-started frames for another ID.
- R5: At the master, a non-sync slave-started frame goes to the application output only, and a non-sync master-started frame is consumed with no output.
- R6: Every delivered or forwarded frame carries its header and payload unchanged.
- R7: A routed frame is held stable on each output it is bound for until that output accepts it. `rx_ready` stays low until every such output has accepted it, and no output receives it twice.
- R8: When several source queues hold frames, the transmit output takes them in the order synchronization, then forwarding, then application.
- R9: While `tx_ready` is low, `tx_valid` and `tx_data` hold; one frame leaves per accepted beat.
- R10: Each source queue holds `FIFO_DEPTH` frames, plus one in the transmit holding stage. Its ready drops once that space is full.
- R11: Frames from one source leave the transmit output in the order they were accepted.
- R12: After reset every output valid is low, and `rx_ready`, `sync_tx_ready` and `app_tx_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | Node acts as ring master |
| node_id | input | 3 | This slave's ring ID (not 7) |
| rx_valid | input | 1 | Received frame present |
| rx_ready | output | 1 | Router takes the received frame |
| rx_data | input | 40 | Received frame, header in bits 39:32 |
| app_rx_valid | output | 1 | Frame for the application |
| app_rx_ready | input | 1 | Application accepts |
| app_rx_data | output | 40 | Frame for the application |
| sync_rx_valid | output | 1 | Frame for the synchronization logic |
| sync_rx_ready | input | 1 | Synchronization logic accepts |
| sync_rx_data | output | 40 | Frame for the synchronization logic |
| sync_tx_valid | input | 1 | Synchronization logic injects a frame |
| sync_tx_ready | output | 1 | Synchronization queue has space |
| sync_tx_data | input | 40 | Injected synchronization frame |
| app_tx_valid | input | 1 | Application injects a frame |
| app_tx_ready | output | 1 | Application queue has space |
| app_tx_data | input | 40 | Injected application frame |
| tx_valid | output | 1 | Frame offered to the transmitter |
| tx_ready | input | 1 | Transmitter idle, takes the frame |
| tx_data | output | 40 | Frame offered to the transmitter |

## Verification
The checker assumes that `is_master` and `node_id` only change while no routed frame is waiting on the application or synchronization output. It also assumes a slave is never given ID 7. The stimulus keeps to both: it changes the role or ID only after a drain gap of several idle cycles, and it uses slave IDs 0, 2 and 5. The hold properties rely on the downstream ready being a free input. The stimulus moves every ready only one nanosecond after a rising edge, never during a frame's acceptance.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    localparam int HDR_W   = 8;
    localparam int PAY_W   = 32;
    localparam int FRAME_W = HDR_W + PAY_W;

    // header field positions inside the frame word
    localparam int ORG_POS = FRAME_W - 1;
    localparam int NODE_HI = FRAME_W - 2;
    localparam int NODE_LO = FRAME_W - 4;
    localparam int KIND_HI = FRAME_W - 5;
    localparam int KIND_LO = FRAME_W - HDR_W;

    typedef logic [FRAME_W-1:0] frame_t;

    // destination set of a routed frame
    typedef logic [2:0] dest_t;
    localparam int D_APP  = 0;
    localparam int D_SYNC = 1;
    localparam int D_FWD  = 2;

    // transmit sources, lower index wins
    localparam int SRC_SYNC = 0;
    localparam int SRC_FWD  = 1;
    localparam int SRC_APP  = 2;
    localparam int N_SRC    = 3;
endpackage

// File: rtl/rfs_route.sv
module rfs_route
    import rfs_pkg::*;
#(
    parameter logic [2:0] MCAST_ID      = 3'd7,
    parameter logic [3:0] SYNC_KIND_MIN = 4'd12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_master,
    input  logic [2:0] node_id,
    input  logic       in_valid,
    output logic       in_ready,
    input  frame_t     in_frame,
    output logic       app_valid,
    input  logic       app_ready,
    output frame_t     app_frame,
    output logic       sync_valid,
    input  logic       sync_ready,
    output frame_t     sync_frame,
    output logic       fwd_valid,
    input  logic       fwd_ready,
    output frame_t     fwd_frame
);
    typedef struct packed {
        dest_t  pend;
        frame_t frame;
    } route_st_t;

    route_st_t  st_d, st_q;
    dest_t      dest_new;
    dest_t      taken;
    dest_t      left;
    logic       morg;
    logic [2:0] nid;
    logic [3:0] kind;

    always_comb begin
        morg = in_frame[ORG_POS];
        nid  = in_frame[NODE_HI:NODE_LO];
        kind = in_frame[KIND_HI:KIND_LO];

        dest_new = '0;
        if (kind >= SYNC_KIND_MIN) begin
            dest_new[D_SYNC] = 1'b1;
        end else if (is_master) begin
            dest_new[D_APP] = !morg;
        end else if (!morg) begin
            dest_new[D_FWD] = 1'b1;
        end else if (nid == MCAST_ID) begin
            dest_new[D_APP] = 1'b1;
            dest_new[D_FWD] = 1'b1;
        end else if (nid == node_id) begin
            dest_new[D_APP] = 1'b1;
        end else begin
            dest_new[D_FWD] = 1'b1;
        end

        taken         = '0;
        taken[D_APP]  = app_ready;
        taken[D_SYNC] = sync_ready;
        taken[D_FWD]  = fwd_ready;
        taken         = taken & st_q.pend;
        left          = st_q.pend & ~taken;
        in_ready      = (left == '0);

        st_d      = st_q;
        st_d.pend = left;
        if (in_valid && in_ready) begin
            st_d.pend  = dest_new;
            st_d.frame = in_frame;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign app_valid  = st_q.pend[D_APP];
    assign sync_valid = st_q.pend[D_SYNC];
    assign fwd_valid  = st_q.pend[D_FWD];
    assign app_frame  = st_q.frame;
    assign sync_frame = st_q.frame;
    assign fwd_frame  = st_q.frame;
endmodule

// File: rtl/rfs_fifo.sv
module rfs_fifo #(
    parameter int W     = 40,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push, pop;

    always_comb begin
        in_ready  = (st_q.cnt != FULL_CNT);
        out_valid = (st_q.cnt != '0);
        out_data  = st_q.mem[st_q.rd];
        push      = in_valid && in_ready;
        pop       = out_valid && out_ready;

        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = in_data;
            st_d.wr = (st_q.wr == LAST_PTR) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == LAST_PTR) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rfs_tx_arb.sv
module rfs_tx_arb #(
    parameter int W = 40,
    parameter int N = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        src_valid,
    output logic [N-1:0]        src_ready,
    input  logic [N-1:0][W-1:0] src_data,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic [W-1:0]        tx_data
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     found;

    always_comb begin
        st_d      = st_q;
        src_ready = '0;
        found     = 1'b0;
        if (!st_q.full || tx_ready) begin
            for (int i = 0; i < N; i++) begin
                if (src_valid[i] && !found) begin
                    found        = 1'b1;
                    src_ready[i] = 1'b1;
                    st_d.data    = src_data[i];
                end
            end
            st_d.full = found;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_valid = st_q.full;
    assign tx_data  = st_q.data;
endmodule

// File: rtl/ring_frame_switch.sv
module ring_frame_switch
    import rfs_pkg::*;
#(
    parameter logic [2:0] MCAST_ID      = 3'd7,
    parameter logic [3:0] SYNC_KIND_MIN = 4'd12,
    parameter int         FIFO_DEPTH    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               is_master,
    input  logic [2:0]         node_id,
    input  logic               rx_valid,
    output logic               rx_ready,
    input  logic [FRAME_W-1:0] rx_data,
    output logic               app_rx_valid,
    input  logic               app_rx_ready,
    output logic [FRAME_W-1:0] app_rx_data,
    output logic               sync_rx_valid,
    input  logic               sync_rx_ready,
    output logic [FRAME_W-1:0] sync_rx_data,
    input  logic               sync_tx_valid,
    output logic               sync_tx_ready,
    input  logic [FRAME_W-1:0] sync_tx_data,
    input  logic               app_tx_valid,
    output logic               app_tx_ready,
    input  logic [FRAME_W-1:0] app_tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [FRAME_W-1:0] tx_data
);
    logic                      fwd_valid, fwd_ready;
    frame_t                    fwd_frame;
    logic [N_SRC-1:0]          q_in_valid, q_in_ready;
    logic [N_SRC-1:0]          q_out_valid, q_out_ready;
    logic [N_SRC-1:0][FRAME_W-1:0] q_in_data, q_out_data;

    rfs_route #(
        .MCAST_ID      (MCAST_ID),
        .SYNC_KIND_MIN (SYNC_KIND_MIN)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_master  (is_master),
        .node_id    (node_id),
        .in_valid   (rx_valid),
        .in_ready   (rx_ready),
        .in_frame   (rx_data),
        .app_valid  (app_rx_valid),
        .app_ready  (app_rx_ready),
        .app_frame  (app_rx_data),
        .sync_valid (sync_rx_valid),
        .sync_ready (sync_rx_ready),
        .sync_frame (sync_rx_data),
        .fwd_valid  (fwd_valid),
        .fwd_ready  (fwd_ready),
        .fwd_frame  (fwd_frame)
    );

    assign q_in_valid[SRC_SYNC] = sync_tx_valid;
    assign q_in_data[SRC_SYNC]  = sync_tx_data;
    assign sync_tx_ready        = q_in_ready[SRC_SYNC];
    assign q_in_valid[SRC_FWD]  = fwd_valid;
    assign q_in_data[SRC_FWD]   = fwd_frame;
    assign fwd_ready            = q_in_ready[SRC_FWD];
    assign q_in_valid[SRC_APP]  = app_tx_valid;
    assign q_in_data[SRC_APP]   = app_tx_data;
    assign app_tx_ready         = q_in_ready[SRC_APP];

    for (genvar g = 0; g < N_SRC; g++) begin : g_srcq
        rfs_fifo #(
            .W     (FRAME_W),
            .DEPTH (FIFO_DEPTH)
        ) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (q_in_valid[g]),
            .in_ready  (q_in_ready[g]),
            .in_data   (q_in_data[g]),
            .out_valid (q_out_valid[g]),
            .out_ready (q_out_ready[g]),
            .out_data  (q_out_data[g])
        );
    end

    rfs_tx_arb #(
        .W (FRAME_W),
        .N (N_SRC)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (q_out_valid),
        .src_ready (q_out_ready),
        .src_data  (q_out_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data)
    );
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker
    import rfs_pkg::*;
#(
    parameter logic [2:0] MCAST_ID      = 3'd7,
    parameter logic [3:0] SYNC_KIND_MIN = 4'd12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               is_master,
    input logic [2:0]         node_id,
    input logic               app_rx_valid,
    input logic               app_rx_ready,
    input logic [FRAME_W-1:0] app_rx_data,
    input logic               sync_rx_valid,
    input logic               sync_rx_ready,
    input logic [FRAME_W-1:0] sync_rx_data,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [FRAME_W-1:0] tx_data
);
    // R1: only sync type codes reach the sync output
    a_r1_sync_kind: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rx_valid |-> (sync_rx_data[KIND_HI:KIND_LO] >= SYNC_KIND_MIN));

    // R2: a slave hands the application only master frames for itself or multicast
    a_r2_slave_app: assert property (@(posedge clk) disable iff (!rst_n)
        (app_rx_valid && !is_master) |->
            (app_rx_data[ORG_POS] &&
             (app_rx_data[KIND_HI:KIND_LO] < SYNC_KIND_MIN) &&
             ((app_rx_data[NODE_HI:NODE_LO] == node_id) ||
              (app_rx_data[NODE_HI:NODE_LO] == MCAST_ID))));

    // R5: the master hands the application only slave-started non-sync frames
    a_r5_master_app: assert property (@(posedge clk) disable iff (!rst_n)
        (app_rx_valid && is_master) |->
            (!app_rx_data[ORG_POS] &&
             (app_rx_data[KIND_HI:KIND_LO] < SYNC_KIND_MIN)));

    // R7: routed frames hold until taken
    a_r7_app_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (app_rx_valid && !app_rx_ready) |=> (app_rx_valid && $stable(app_rx_data)));

    a_r7_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_rx_valid && !sync_rx_ready) |=> (sync_rx_valid && $stable(sync_rx_data)));

    // R9: transmitter offer holds while busy
    a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind ring_frame_switch rfs_checker #(
    .MCAST_ID      (MCAST_ID),
    .SYNC_KIND_MIN (SYNC_KIND_MIN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .is_master     (is_master),
    .node_id       (node_id),
    .app_rx_valid  (app_rx_valid),
    .app_rx_ready  (app_rx_ready),
    .app_rx_data   (app_rx_data),
    .sync_rx_valid (sync_rx_valid),
    .sync_rx_ready (sync_rx_ready),
    .sync_rx_data  (sync_rx_data),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data)
);

// File: tb/tb_ring_frame_switch.sv
module tb_ring_frame_switch;
    import rfs_pkg::*;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       is_master;
    logic [2:0] node_id;
    logic       rx_valid, rx_ready;
    frame_t     rx_data;
    logic       app_rx_valid, app_rx_ready;
    frame_t     app_rx_data;
    logic       sync_rx_valid, sync_rx_ready;
    frame_t     sync_rx_data;
    logic       sync_tx_valid, sync_tx_ready;
    frame_t     sync_tx_data;
    logic       app_tx_valid, app_tx_ready;
    frame_t     app_tx_data;
    logic       tx_valid, tx_ready;
    frame_t     tx_data;

    always #4 clk = ~clk;

    ring_frame_switch #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .node_id(node_id),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .app_rx_valid(app_rx_valid), .app_rx_ready(app_rx_ready), .app_rx_data(app_rx_data),
        .sync_rx_valid(sync_rx_valid), .sync_rx_ready(sync_rx_ready), .sync_rx_data(sync_rx_data),
        .sync_tx_valid(sync_tx_valid), .sync_tx_ready(sync_tx_ready), .sync_tx_data(sync_tx_data),
        .app_tx_valid(app_tx_valid), .app_tx_ready(app_tx_ready), .app_tx_data(app_tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    int     total = 0;
    int     bad = 0;
    bit     finished = 1'b0;
    int     app_cnt = 0;
    int     sync_cnt = 0;
    int     tx_cnt = 0;
    frame_t app_last, sync_last;
    frame_t tx_log [2048];

    // handshake monitor, half a cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (app_rx_valid && app_rx_ready) begin
                app_cnt++;
                app_last = app_rx_data;
            end
            if (sync_rx_valid && sync_rx_ready) begin
                sync_cnt++;
                sync_last = sync_rx_data;
            end
            if (tx_valid && tx_ready) begin
                if (tx_cnt < 2048) tx_log[tx_cnt] = tx_data;
                tx_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send_rx(input frame_t f);
        step();
        rx_valid = 1'b1;
        rx_data  = f;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic push_app(input frame_t f);
        step();
        app_tx_valid = 1'b1;
        app_tx_data  = f;
        step();
        app_tx_valid = 1'b0;
    endtask

    task automatic push_sync(input frame_t f);
        step();
        sync_tx_valid = 1'b1;
        sync_tx_data  = f;
        step();
        sync_tx_valid = 1'b0;
    endtask

    // expected destination set: bit0 app, bit1 sync, bit2 forward
    function automatic logic [2:0] exp_dest(input logic [7:0] h, input logic m,
                                            input logic [2:0] id);
        if (h[3:0] >= 4'd12) return 3'b010;
        if (m)               return h[7] ? 3'b000 : 3'b001;
        if (!h[7])           return 3'b100;
        if (h[6:4] == 3'd7)  return 3'b101;
        if (h[6:4] == id)    return 3'b001;
        return 3'b100;
    endfunction

    function automatic string tag_of(input logic [7:0] h, input logic m,
                                     input logic [2:0] id);
        if (h[3:0] >= 4'd12) return "R1";
        if (m)               return "R5";
        if (!h[7])           return "R4";
        if (h[6:4] == 3'd7)  return "R3";
        if (h[6:4] == id)    return "R2";
        return "R4";
    endfunction

    initial begin
        repeat (120000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; is_master = 1'b0; node_id = 3'd0;
        rx_valid = 1'b0; rx_data = '0;
        sync_tx_valid = 1'b0; sync_tx_data = '0;
        app_tx_valid = 1'b0; app_tx_data = '0;
        app_rx_ready = 1'b1; sync_rx_ready = 1'b1; tx_ready = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(!app_rx_valid && !sync_rx_valid && !tx_valid, "R12", "valids",
              {app_rx_valid, sync_rx_valid, tx_valid}, 0);
        check(rx_ready && sync_tx_ready && app_tx_ready, "R12", "readys",
              {rx_ready, sync_tx_ready, app_tx_ready}, 3'b111);

        // exhaustive header sweep over four node configurations
        for (int cfg = 0; cfg < 4; cfg++) begin
            step();
            is_master = (cfg == 0);
            node_id   = (cfg == 3) ? 3'd5 : (cfg == 2) ? 3'd2 : 3'd0;
            repeat (2) step();
            for (int h = 0; h < 256; h++) begin
                frame_t     f;
                logic [2:0] e;
                string      tg;
                int         a0, s0, t0;
                f  = {8'(h), 32'h5A00_0000 ^ (32'(h) << 8) ^ 32'(cfg)};
                e  = exp_dest(8'(h), is_master, node_id);
                tg = tag_of(8'(h), is_master, node_id);
                a0 = app_cnt; s0 = sync_cnt; t0 = tx_cnt;
                send_rx(f);
                repeat (6) step();
                @(negedge clk);
                check(app_cnt - a0 == int'(e[0]), tg, "app count", app_cnt - a0, e[0]);
                check(sync_cnt - s0 == int'(e[1]), tg, "sync count", sync_cnt - s0, e[1]);
                check(tx_cnt - t0 == int'(e[2]), tg, "forward count", tx_cnt - t0, e[2]);
                if (e[0]) check(app_last == f, "R6", "app data", app_last, f);
                if (e[1]) check(sync_last == f, "R6", "sync data", sync_last, f);
                if (e[2] && t0 < 2048) check(tx_log[t0] == f, "R6", "forward data", tx_log[t0], f);
            end
        end

        // R7: multicast with a stalled application output
        begin
            frame_t f;
            int     a0, t0;
            step();
            is_master = 1'b0; node_id = 3'd2; app_rx_ready = 1'b0;
            repeat (2) step();
            f  = {8'hF1, 32'hC0DE_0007};
            a0 = app_cnt; t0 = tx_cnt;
            send_rx(f);
            repeat (3) step();
            @(negedge clk);
            check(rx_ready == 1'b0, "R7", "rx_ready while app pending", rx_ready, 0);
            check(app_rx_valid && app_rx_data == f, "R7", "app held", app_rx_data, f);
            check(tx_cnt - t0 == 1, "R3", "forward done while app stalls", tx_cnt - t0, 1);
            step();
            app_rx_ready = 1'b1;
            repeat (3) step();
            @(negedge clk);
            check(app_cnt - a0 == 1, "R7", "app delivered once", app_cnt - a0, 1);
            check(tx_cnt - t0 == 1, "R7", "no second forward", tx_cnt - t0, 1);
            check(rx_ready == 1'b1, "R7", "rx_ready after release", rx_ready, 1);
        end

        // R8 and R9: priority order behind a busy transmitter
        begin
            frame_t a1, a2, s1, f1;
            int     t0;
            a1 = {8'h80, 32'hA000_0001};
            a2 = {8'h80, 32'hA000_0002};
            s1 = {8'h8C, 32'h5000_0001};
            f1 = {8'h01, 32'hF000_0001};
            step();
            tx_ready = 1'b0;
            t0 = tx_cnt;
            push_app(a1);
            repeat (3) step();
            push_sync(s1);
            send_rx(f1);
            push_app(a2);
            repeat (4) step();
            @(negedge clk);
            check(tx_valid && tx_data == a1, "R9", "held offer", tx_data, a1);
            repeat (3) step();
            @(negedge clk);
            check(tx_valid && tx_data == a1, "R9", "offer stable", tx_data, a1);
            check(tx_cnt == t0, "R9", "nothing sent while busy", tx_cnt - t0, 0);
            step();
            tx_ready = 1'b1;
            repeat (8) step();
            @(negedge clk);
            check(tx_cnt - t0 == 4, "R8", "frames sent", tx_cnt - t0, 4);
            check(tx_log[t0] == a1, "R8", "slot 0", tx_log[t0], a1);
            check(tx_log[t0 + 1] == s1, "R8", "slot 1 sync", tx_log[t0 + 1], s1);
            check(tx_log[t0 + 2] == f1, "R8", "slot 2 forward", tx_log[t0 + 2], f1);
            check(tx_log[t0 + 3] == a2, "R8", "slot 3 app", tx_log[t0 + 3], a2);
        end

        // R10 and R11: fill the application queue, then drain in order
        begin
            int acc, t0;
            bit stop;
            acc = 0; stop = 1'b0;
            step();
            tx_ready = 1'b0;
            t0 = tx_cnt;
            for (int i = 0; i < 10; i++) begin
                if (!stop) begin
                    step();
                    app_tx_valid = 1'b1;
                    app_tx_data  = {8'hB0, 32'(acc)};
                    @(negedge clk);
                    if (app_tx_ready) acc++;
                    else stop = 1'b1;
                end
            end
            step();
            app_tx_valid = 1'b0;
            check(acc == DEPTH + 1, "R10", "frames accepted", acc, DEPTH + 1);
            check(app_tx_ready == 1'b0, "R10", "ready when full", app_tx_ready, 0);
            tx_ready = 1'b1;
            repeat (12) step();
            @(negedge clk);
            check(tx_cnt - t0 == DEPTH + 1, "R11", "drained", tx_cnt - t0, DEPTH + 1);
            for (int k = 0; k < DEPTH + 1; k++) begin
                check(tx_log[t0 + k] == {8'hB0, 32'(k)}, "R11", "order",
                      tx_log[t0 + k], {8'hB0, 32'(k)});
            end
            check(app_tx_ready == 1'b1, "R10", "ready after drain", app_tx_ready, 1);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule